// File: doc/BRIEF.md
# Boundary-Scan Wrapped Octal Register

An eight-bit D-type register with a functional clock pin and an output-enable pin, surrounded by serial test logic that follows the usual four-wire test access port conventions. A sixteen-state controller, advanced by the test mode input on each rising test clock, steers a two-bit instruction register, a one-bit bypass stage and an eighteen-cell boundary chain. The chain has one cell for each of the eight data inputs, the functional clock, the output enable and the eight data outputs.

During normal operation the core register drives the outputs. A board tester can instead sample every pin without disturbing the core. It can preload patterns into the parallel update latches and then hand the output pins and their drive enable over to those latches. This lets the tester check the board wiring around the part. When the part has no work to do in a long chain, the bypass stage shortens its serial contribution to a single bit.

Top module: `bscan_octal_reg`

## Requirements
- R1: While `trst_n` is low, and whenever the controller sits in its reset state, the bypass instruction is in force. `tdo_oe` is 0, and `q_pin`/`q_drive` follow the core register and `oe_pin`.
- R2: Five consecutive rising test clocks with `tms` = 1 bring the controller to its reset state from any state, so the bypass instruction is selected.
- R3: The instruction register is 2 bits wide and shifts least significant bit first. Capture-IR loads 01, so the first bit out is 1 and the second is 0. Codes: 00 = external test, 01 = sample/preload, 11 = bypass. A new code takes effect on the falling edge in Update-IR.
- R4: Capture-DR loads the chain with cell k = `d_in[k]` for k = 0..7, cell 8 = `clk_pin`, cell 9 = `oe_pin`, and cell 10+k = core register bit k. Cell 0 sits next to `tdo`, and `tdi` enters at cell 17.
- R5: The chain is 18 cells long. A bit presented on `tdi` during Shift-DR reappears on `tdo` 18 shifts later.
- R6: Under bypass, Capture-DR loads 0 into the single bypass stage. Each `tdi` bit appears on `tdo` one shift later.
- R7: Under external test, `q_pin` equals update cells 17..10 and `q_drive` equals update cell 9. Clocking the core register has no effect on the pins.
- R8: Under sample/preload the core drives the pins. Update-DR still fills the update latches, and their contents appear on the pins as soon as external test is loaded.
- R9: The update latches, and so the pins under external test, change on the falling test clock edge in Update-DR, not on the rising edge that enters it.
- R10: `tdo_oe` is 1 only during Shift-DR and Shift-IR. `tdo` changes only on falling test clock edges.
- R11: The unassigned code 10 behaves as bypass: the serial path is one stage that captures 0, and the pins stay with the core.
- R12: The core register loads `d_in` on each rising edge of `clk_pin`. Outside external test, `q_drive` equals `oe_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, valid while `tdo_oe` is 1 |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| d_in | input | 8 | Functional data inputs |
| clk_pin | input | 1 | Functional register clock |
| oe_pin | input | 1 | Functional output enable, 1 = drive |
| q_pin | output | 8 | Data output pins |
| q_drive | output | 1 | Output drive enable for `q_pin` |

## Verification
The serial path is exercised with short bypass scans after reset and under the unassigned code. A delay of one stage with a leading 0 tells those apart from the long chain. A 36-bit sample scan with different bit values on data, clock, enable and core cells shows both the cell order and the 18-stage length, because the second half returns the first half of the shifted-in pattern. A preload followed by a switch to external test, an 18-bit external scan that checks the pins before and after the falling edge in Update-DR, and core clocking during external test together separate the three sources that can drive the pins. A mid-scan escape with `tms` held high confirms that the pins fall back to the core.

// File: rtl/bscan_octal_reg.sv
`timescale 1ns/1ps
module bscan_octal_reg #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tms,
  input  logic         tdi,
  output logic         tdo,
  output logic         tdo_oe,
  input  logic [W-1:0] d_in,
  input  logic         clk_pin,
  input  logic         oe_pin,
  output logic [W-1:0] q_pin,
  output logic         q_drive
);
  localparam int N       = 2*W + 2;
  localparam int OE_CELL = W + 1;
  localparam int Q_LO    = W + 2;

  localparam logic [3:0] S_RESET = 4'd0,  S_IDLE  = 4'd1,  S_SEL_DR = 4'd2,  S_CAP_DR = 4'd3,
                         S_SH_DR = 4'd4,  S_X1_DR = 4'd5,  S_PA_DR  = 4'd6,  S_X2_DR  = 4'd7,
                         S_UP_DR = 4'd8,  S_SEL_IR = 4'd9, S_CAP_IR = 4'd10, S_SH_IR  = 4'd11,
                         S_X1_IR = 4'd12, S_PA_IR = 4'd13, S_X2_IR  = 4'd14, S_UP_IR  = 4'd15;
  localparam logic [1:0] I_EXTEST = 2'b00, I_SAMPLE = 2'b01, I_BYPASS = 2'b11;

  logic [3:0]   state, nxt;
  logic [1:0]   ir, ir_sr;
  logic [N-1:0] sr, upd;
  logic         byp;
  logic [W-1:0] q_core;

  always_ff @(posedge clk_pin) q_core <= d_in;

  always_comb begin
    case (state)
      S_RESET:  nxt = tms ? S_RESET  : S_IDLE;
      S_IDLE:   nxt = tms ? S_SEL_DR : S_IDLE;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_X1_DR  : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_X1_DR  : S_SH_DR;
      S_X1_DR:  nxt = tms ? S_UP_DR  : S_PA_DR;
      S_PA_DR:  nxt = tms ? S_X2_DR  : S_PA_DR;
      S_X2_DR:  nxt = tms ? S_UP_DR  : S_SH_DR;
      S_UP_DR:  nxt = tms ? S_SEL_DR : S_IDLE;
      S_SEL_IR: nxt = tms ? S_RESET  : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_X1_IR  : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_X1_IR  : S_SH_IR;
      S_X1_IR:  nxt = tms ? S_UP_IR  : S_PA_IR;
      S_PA_IR:  nxt = tms ? S_X2_IR  : S_PA_IR;
      S_X2_IR:  nxt = tms ? S_UP_IR  : S_SH_IR;
      default:  nxt = tms ? S_SEL_DR : S_IDLE;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= S_RESET;
    else         state <= nxt;

  logic use_chain;
  assign use_chain = (ir == I_EXTEST) || (ir == I_SAMPLE);

  always_ff @(posedge tck) begin
    if (state == S_CAP_IR)     ir_sr <= 2'b01;
    else if (state == S_SH_IR) ir_sr <= {tdi, ir_sr[1]};
    if (state == S_CAP_DR) begin
      byp <= 1'b0;
      if (use_chain) sr <= {q_core, oe_pin, clk_pin, d_in};
    end else if (state == S_SH_DR) begin
      byp <= tdi;
      if (use_chain) sr <= {tdi, sr[N-1:1]};
    end
  end

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      ir     <= I_BYPASS;
      upd    <= '0;
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      if (state == S_RESET)      ir <= I_BYPASS;
      else if (state == S_UP_IR) ir <= ir_sr;
      if (state == S_UP_DR && use_chain) upd <= sr;
      tdo_oe <= (state == S_SH_DR) || (state == S_SH_IR);
      tdo    <= (state == S_SH_IR) ? ir_sr[0] : (use_chain ? sr[0] : byp);
    end

  assign q_pin   = (ir == I_EXTEST) ? upd[N-1:Q_LO] : q_core;
  assign q_drive = (ir == I_EXTEST) ? upd[OE_CELL]  : oe_pin;
endmodule

// File: rtl/bscan_octal_reg_chk.sv
`timescale 1ns/1ps
module bscan_octal_reg_chk #(
  parameter int W = 8
) (
  input logic         tck,
  input logic         trst_n,
  input logic         tms,
  input logic [3:0]   state,
  input logic [1:0]   ir,
  input logic [1:0]   ir_sr,
  input logic         byp,
  input logic [W-1:0] q_pin,
  input logic         q_drive,
  input logic         tdo_oe
);
  localparam logic [3:0] S_RESET = 4'd0, S_CAP_DR = 4'd3, S_SH_DR = 4'd4, S_UP_DR = 4'd8,
                         S_CAP_IR = 4'd10, S_SH_IR = 4'd11;
  localparam logic [1:0] I_EXTEST = 2'b00, I_BYPASS = 2'b11;

  // R1
  reset_selects_bypass_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_RESET) |=> (ir == I_BYPASS));

  // R2
  five_ones_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (state == S_RESET));

  // R3
  ir_capture_pattern_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAP_IR) |=> (ir_sr == 2'b01));

  // R6
  bypass_capture_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAP_DR) |=> !byp);

  // R9
  pins_hold_outside_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir == I_EXTEST && $past(ir) == I_EXTEST && state != S_UP_DR) |-> ($stable(q_pin) && $stable(q_drive)));

  // R10
  tdo_enable_in_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == S_SH_DR || state == S_SH_IR));
endmodule

bind bscan_octal_reg bscan_octal_reg_chk #(.W(W)) u_chk (.*);

// File: tb/sim_bscan_octal_reg.sv
`timescale 1ns/1ps
module sim_bscan_octal_reg;
  logic       tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic       clk_pin = 1'b0, oe_pin = 1'b1;
  logic [7:0] d_in = 8'h00;
  logic       tdo, tdo_oe, q_drive;
  logic [7:0] q_pin;
  logic [7:0] qc;
  logic [17:0] upd_m;
  int  checks = 0, fails = 0;
  bit  done = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #2 tck = ~tck;

  bscan_octal_reg u0 (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
                      .d_in(d_in), .clk_pin(clk_pin), .oe_pin(oe_pin), .q_pin(q_pin), .q_drive(q_drive));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: each queued item is one shift; tdo must still hold the bit set at the prior falling edge (R10)
  always @(posedge tck) begin
    if (exp_q.size() != 0) begin
      bit e;
      string t;
      #1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(tdo === e && tdo_oe === 1'b1, t, {tdo_oe, tdo}, {1'b1, e});
    end
  end

  task automatic step(input bit m, input bit i);
    tms = m; tdi = i;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic sbit(input bit m, input bit i, input bit e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    step(m, i);
  endtask

  task automatic load_ir(input logic [1:0] c);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    sbit(0, c[0], 1'b1, "R3");
    sbit(1, c[1], 1'b0, "R3");
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [35:0] din, input logic [35:0] ex,
                         input string t_lo, input string t_hi,
                         input bit chk_upd, input logic [8:0] oldp, input logic [8:0] newp);
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < n; k++) sbit(k == n-1, din[k], ex[k], (k < 18) ? t_lo : t_hi);
    tms = 1'b1;
    @(posedge tck); #1;
    if (chk_upd) chk({q_drive, q_pin} === oldp, "R9 before falling edge", {q_drive, q_pin}, oldp);
    @(negedge tck); #1;
    if (chk_upd) chk({q_drive, q_pin} === newp, "R9 after falling edge", {q_drive, q_pin}, newp);
    step(0, 0);
  endtask

  function automatic logic [35:0] byp_exp(input logic [35:0] v);
    return {v[34:0], 1'b0};
  endfunction

  function automatic logic [35:0] dr_exp(input logic [35:0] v, input logic [17:0] cap);
    return {v[17:0], cap};
  endfunction

  task automatic core_clk(input logic [7:0] v);
    clk_pin = 1'b0; #0.5; d_in = v; clk_pin = 1'b1; #0.5; qc = v;
  endtask

  initial begin
    logic [35:0] v;
    logic [8:0]  oldp;
    #5;
    chk(tdo_oe === 1'b0, "R1", tdo_oe, 0);
    chk(q_drive === 1'b1, "R1", q_drive, 1);
    trst_n = 1'b1;
    @(negedge tck); #1;
    core_clk(8'hA5);
    chk(q_pin === 8'hA5, "R12", q_pin, 8'hA5);
    step(0, 0);
    chk(tdo_oe === 1'b0, "R10", tdo_oe, 0);

    v = 36'h2D;
    scan_dr(6, v, byp_exp(v), "R1", "R1", 0, 9'h0, 9'h0);
    chk(q_pin === qc, "R1", q_pin, qc);

    d_in = 8'h3C; oe_pin = 1'b0; #0.5;
    chk({q_drive, q_pin} === {1'b0, qc}, "R12", {q_drive, q_pin}, {1'b0, qc});

    load_ir(2'b01);
    v = {18'h3AB6D, 18'h2B4C1};
    scan_dr(36, v, dr_exp(v, {qc, oe_pin, clk_pin, d_in}), "R4", "R5", 0, 9'h0, 9'h0);
    upd_m = v[35:18];
    chk({q_drive, q_pin} === {oe_pin, qc}, "R8", {q_drive, q_pin}, {oe_pin, qc});

    load_ir(2'b00);
    chk({q_drive, q_pin} === {upd_m[9], upd_m[17:10]}, "R8", {q_drive, q_pin}, {upd_m[9], upd_m[17:10]});
    oldp = {upd_m[9], upd_m[17:10]};
    core_clk(8'h0F);
    #1;
    chk({q_drive, q_pin} === oldp, "R7", {q_drive, q_pin}, oldp);

    d_in = 8'hC3; oe_pin = 1'b1;
    v = {18'h0, 18'h1E5A7};
    scan_dr(18, v, dr_exp(v, {qc, oe_pin, clk_pin, d_in}), "R4", "R4", 1, oldp, {v[9], v[17:10]});
    upd_m = v[17:0];
    chk({q_drive, q_pin} === {upd_m[9], upd_m[17:10]}, "R7", {q_drive, q_pin}, {upd_m[9], upd_m[17:10]});

    step(1, 0); step(0, 0); step(0, 0);
    repeat (5) step(1, 0);
    chk({q_drive, q_pin} === {oe_pin, qc}, "R2", {q_drive, q_pin}, {oe_pin, qc});
    chk(tdo_oe === 1'b0, "R2", tdo_oe, 0);
    step(0, 0);

    load_ir(2'b10);
    v = 36'h15;
    scan_dr(5, v, byp_exp(v), "R11", "R11", 0, 9'h0, 9'h0);
    chk({q_drive, q_pin} === {oe_pin, qc}, "R11", {q_drive, q_pin}, {oe_pin, qc});
    oe_pin = 1'b0; #0.5;
    chk(q_drive === 1'b0, "R12", q_drive, 0);
    chk(tdo_oe === 1'b0, "R10", tdo_oe, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule